// File: doc/BRIEF.md
# FSK Tone Synthesizer

This block is the digital core of a frequency-shift-keyed transmitter. It runs from a 16 MHz reference and produces a stream of signed sine samples for an external DAC. The samples carry one of two tones. The tones sit symmetrically around a carrier that is picked from eight channels. How far apart the two tones are follows from the selected symbol rate and from a deviation setting. Each transmit data bit picks one of the two tones.

The host can feed data in two ways. In asynchronous mode the data input steers the tone directly, so the host controls bit timing. In synchronous mode the block generates its own bit clock at the selected symbol rate and captures the data input when that clock rises. Neither mode adds framing bits.

A tone switch, or a configuration change, takes effect only when the running half sine period ends, that is, at a zero crossing of the output. This keeps the waveform free of steps.

Top module: `fsk_tone_synth`

## Requirements
- R1: `chan_sel` picks the carrier. Codes 0 to 7 give 60000, 66000, 72000, 76000, 82050, 86000, 110000 and 132500 Hz.
- R2: `baud_sel` codes 0 to 3 give 600, 1200, 2400 and 4800 baud. The tone spacing is the symbol rate with `dev_full`=1 and half the symbol rate with `dev_full`=0. Data 0 selects carrier + spacing/2 and data 1 selects carrier - spacing/2. Each tone advances a 24-bit phase by round(f * 2^24 / 16e6) per clock.
- R3: The combination `baud_sel`=3 with `dev_full`=0 is not permitted. The block treats it as `dev_full`=1.
- R4: While `tx_en` is high, the phase advances by the active increment on every clock. While `tx_en` is low, the phase is held at 0, `dac_code` reads 0 and `bit_clk` is low, all from the next clock on.
- R5: A newly requested tone or configuration replaces the active increment only on a clock where phase bit 23 changes value. During the same clock the phase keeps advancing by the old increment.
- R6: `dac_code` is a registered signed sample, one clock behind the phase. It approximates 511 * sin(2*pi*(k+0.5)/256) within 3 LSB, where k is phase bits 23:16.
- R7: In synchronous mode (`sync_mode`=1), `bit_clk` is bit 23 of a second 24-bit accumulator. That accumulator adds round(baud * 2^24 / 16e6) per clock while `tx_en` is high and is cleared while `tx_en` is low. `tx_data` is captured on the clock where `bit_clk` goes high, and the captured bit is the requested symbol.
- R8: In asynchronous mode (`sync_mode`=0), the live `tx_data` is the requested symbol. No bits are inserted.
- R9: While reset is asserted, and for two clocks after it is released, `dac_code` is 0 and `bit_clk` is 0.
- R10: `dac_code` never takes the value -512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 3 | Carrier channel code |
| baud_sel | input | 2 | Symbol rate code |
| dev_full | input | 1 | 1: spacing equals symbol rate, 0: half of it |
| tx_data | input | 1 | Data bit to transmit |
| tx_en | input | 1 | Transmit enable |
| sync_mode | input | 1 | 1: internal bit clock captures data, 0: data is used directly |
| dac_code | output | 10 | Signed sine sample |
| bit_clk | output | 1 | Internal bit clock |

## Verification
The bench toggles data far faster than a half tone period. A design that switched tones without waiting for the zero crossing would diverge from the model within a few clocks. The forbidden rate and deviation pair is driven on its own, so a design that kept the narrow spacing there would produce the wrong phase slope. Synchronous runs check that data is captured exactly on the bit clock rise; capturing one clock early or late would shift every symbol boundary. Disable pulses in the middle of a tone check that the phase restarts at zero.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  localparam int PHASE_W = 24;
  localparam longint unsigned CLK_HZ = 64'd16000000;
  localparam int CHAN_W = 3;
  localparam int BAUD_W = 2;
  localparam int CFG_W = CHAN_W + BAUD_W + 2;

  function automatic longint unsigned carrier_hz(input logic [CHAN_W-1:0] c);
    case (c)
      3'd0: return 64'd60000;
      3'd1: return 64'd66000;
      3'd2: return 64'd72000;
      3'd3: return 64'd76000;
      3'd4: return 64'd82050;
      3'd5: return 64'd86000;
      3'd6: return 64'd110000;
      default: return 64'd132500;
    endcase
  endfunction

  function automatic longint unsigned baud_hz(input logic [BAUD_W-1:0] b);
    return 64'd600 << b;
  endfunction

  // frequency in Hz to per-clock phase step, rounded to nearest
  function automatic logic [PHASE_W-1:0] hz_to_step(input longint unsigned f);
    longint unsigned s;
    s = ((f << PHASE_W) + CLK_HZ / 2) / CLK_HZ;
    return s[PHASE_W-1:0];
  endfunction

  function automatic logic [PHASE_W-1:0] tone_step(input logic [CHAN_W-1:0] ch,
                                                   input logic [BAUD_W-1:0] bd,
                                                   input logic dev, input logic sym);
    longint unsigned half;
    logic wide;
    wide = dev | (bd == 2'd3);  // narrow spacing at top rate is forbidden
    half = wide ? baud_hz(bd) / 2 : baud_hz(bd) / 4;
    return hz_to_step(sym ? carrier_hz(ch) - half : carrier_hz(ch) + half);
  endfunction
endpackage

// File: rtl/fsk_step_rom.sv
module fsk_step_rom
  import fsk_pkg::*;
(
  input  logic [CFG_W-1:0]   addr,
  output logic [PHASE_W-1:0] step
);
  localparam int DEPTH = 1 << CFG_W;

  logic [PHASE_W-1:0] tab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [CFG_W-1:0] IDX = CFG_W'(i);
    assign tab[i] = tone_step(IDX[CFG_W-1 -: CHAN_W], IDX[BAUD_W+1:2], IDX[1], IDX[0]);
  end

  assign step = tab[addr];
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut #(
  parameter int QA_W  = 6,
  parameter int DAC_W = 10
) (
  input  logic [QA_W+1:0]          phase_top,
  output logic signed [DAC_W-1:0]  sample
);
  localparam int QN  = 1 << QA_W;
  localparam int AMP = (1 << (DAC_W - 1)) - 1;
  localparam int HP  = 4 * QN;  // half turn in bin-centre units

  // rational sine approximation evaluated at bin centres
  function automatic int qval(input int i);
    longint x, t, v;
    x = 2 * i + 1;
    t = x * (HP - x);
    v = (AMP * 16 * t) / (5 * HP * HP - 4 * t);
    return int'(v);
  endfunction

  logic [DAC_W-2:0] tab [QN];
  for (genvar i = 0; i < QN; i++) begin : g_q
    assign tab[i] = (DAC_W-1)'(qval(i));
  end

  logic             neg_half, falling;
  logic [QA_W-1:0]  idx;
  logic [DAC_W-2:0] mag;

  always_comb begin
    neg_half = phase_top[QA_W+1];
    falling  = phase_top[QA_W];
    idx      = falling ? ~phase_top[QA_W-1:0] : phase_top[QA_W-1:0];
    mag      = tab[idx];
    sample   = neg_half ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  always_comb begin
    a_r10_no_full_neg: assert (sample != $signed({1'b1, {(DAC_W-1){1'b0}}}));
  end
endmodule

// File: rtl/fsk_bit_clock.sv
module fsk_bit_clock
  import fsk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BAUD_W-1:0] baud_sel,
  output logic              bit_clk,
  output logic              rise
);
  logic [PHASE_W-1:0] acc_q, acc_n, acc_sum, step;
  logic [PHASE_W-1:0] steps [1 << BAUD_W];

  for (genvar b = 0; b < (1 << BAUD_W); b++) begin : g_rate
    assign steps[b] = hz_to_step(baud_hz(BAUD_W'(b)));
  end

  always_comb begin
    step    = steps[baud_sel];
    acc_sum = acc_q + step;
    rise    = en & ~acc_q[PHASE_W-1] & acc_sum[PHASE_W-1];
    acc_n   = en ? acc_sum : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end

  assign bit_clk = acc_q[PHASE_W-1];
endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth
  import fsk_pkg::*;
#(
  parameter int QA_W  = 6,
  parameter int DAC_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CHAN_W-1:0]       chan_sel,
  input  logic [BAUD_W-1:0]       baud_sel,
  input  logic                    dev_full,
  input  logic                    tx_data,
  input  logic                    tx_en,
  input  logic                    sync_mode,
  output logic signed [DAC_W-1:0] dac_code,
  output logic                    bit_clk
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [PHASE_W-1:0] phase_q, phase_n, phase_sum, step_q, step_n, rom_step;
  logic               sym_q, sym_n, sym_req, rom_sym, crossing, bclk_rise;
  logic signed [DAC_W-1:0] lut_out, dac_n;

  fsk_bit_clock u_bclk (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (tx_en),
    .baud_sel(baud_sel),
    .bit_clk (bit_clk),
    .rise    (bclk_rise)
  );

  fsk_step_rom u_rom (
    .addr({chan_sel, baud_sel, dev_full, rom_sym}),
    .step(rom_step)
  );

  fsk_sine_lut #(.QA_W(QA_W), .DAC_W(DAC_W)) u_lut (
    .phase_top(phase_q[PHASE_W-1 -: QA_W+2]),
    .sample   (lut_out)
  );

  always_comb begin
    phase_sum = phase_q + step_q;
    crossing  = phase_sum[PHASE_W-1] ^ phase_q[PHASE_W-1];
    sym_req   = sync_mode ? sym_q : tx_data;
    rom_sym   = tx_en ? sym_req : tx_data;
    if (!tx_en) begin
      phase_n = '0;
      step_n  = rom_step;
      sym_n   = tx_data;
      dac_n   = '0;
    end else begin
      phase_n = phase_sum;
      step_n  = crossing ? rom_step : step_q;
      sym_n   = bclk_rise ? tx_data : sym_q;
      dac_n   = lut_out;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q  <= '0;
      step_q   <= '0;
      sym_q    <= 1'b0;
      dac_code <= '0;
    end else begin
      phase_q  <= phase_n;
      step_q   <= step_n;
      sym_q    <= sym_n;
      dac_code <= dac_n;
    end
  end

  a_r5_step_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_en && !crossing) |=> $stable(step_q));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    !tx_en |=> (dac_code == '0 && !bit_clk));

  a_r7_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_en && sync_mode) |=> ($rose(bit_clk) || $stable(sym_q)));

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (dac_code == '0 && !bit_clk));
endmodule

// File: tb/fsk_tone_synth_test.sv
module fsk_tone_synth_test;
  localparam int CLK_PERIOD = 10;
  localparam longint MASK = 64'hFFFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] chan_sel = 3'd0;
  logic [1:0] baud_sel = 2'd0;
  logic dev_full = 1'b1, tx_data = 1'b0, tx_en = 1'b0, sync_mode = 1'b0;
  logic signed [9:0] dac_code;
  logic bit_clk;

  fsk_tone_synth uut (.clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .baud_sel(baud_sel),
    .dev_full(dev_full), .tx_data(tx_data), .tx_en(tx_en), .sync_mode(sync_mode),
    .dac_code(dac_code), .bit_clk(bit_clk));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fails = 0;
  string tag = "R9";
  bit done = 0;

  function automatic longint tone_m(int ch, int bd, bit dev, bit d);
    real fc, baud, half, f;
    case (ch)
      0: fc = 60000.0;  1: fc = 66000.0;  2: fc = 72000.0;  3: fc = 76000.0;
      4: fc = 82050.0;  5: fc = 86000.0;  6: fc = 110000.0; default: fc = 132500.0;
    endcase
    baud = 600.0 * (1 << bd);
    half = (dev || bd == 3) ? baud / 2.0 : baud / 4.0;
    f = d ? fc - half : fc + half;
    return longint'($rtoi(f * 16777216.0 / 16.0e6 + 0.5));
  endfunction

  function automatic longint baud_m(int bd);
    return longint'($rtoi(600.0 * (1 << bd) * 16777216.0 / 16.0e6 + 0.5));
  endfunction

  // model state
  longint m_ph = 0, m_inc = 0, m_bacc = 0;
  bit m_sym = 0, m_exact = 1, m_bclk = 0;
  real m_exp = 0.0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_inc = 0; m_bacc = 0; m_sym = 0; m_exact = 1; m_exp = 0.0;
    end else if (!tx_en) begin
      m_ph = 0; m_bacc = 0; m_sym = tx_data; m_exact = 1; m_exp = 0.0;
      m_inc = tone_m(chan_sel, baud_sel, dev_full, tx_data);
    end else begin
      longint nph, nb, k;
      bit req;
      k = m_ph >> 16;
      m_exp = 511.0 * $sin(2.0 * 3.14159265358979 * (real'(k) + 0.5) / 256.0);
      m_exact = 0;
      req = sync_mode ? m_sym : tx_data;
      nph = (m_ph + m_inc) & MASK;
      if (((nph >> 23) & 1) != ((m_ph >> 23) & 1))
        m_inc = tone_m(chan_sel, baud_sel, dev_full, req);
      m_ph = nph;
      nb = (m_bacc + baud_m(baud_sel)) & MASK;
      if (((m_bacc >> 23) & 1) == 0 && ((nb >> 23) & 1) == 1) m_sym = tx_data;
      m_bacc = nb;
    end
    m_bclk = ((m_bacc >> 23) & 1) == 1;
  end

  always @(negedge clk) begin
    if (!done) begin
      real diff;
      diff = real'(dac_code) - m_exp;
      n_checks++;
      if (m_exact ? (dac_code != 0) : (diff > 3.0 || diff < -3.0)) begin
        n_fails++;
        $display("FAIL R6 (%s): dac_code=%0d expected=%0.1f", tag, dac_code, m_exp);
      end
      n_checks++;
      if (bit_clk !== m_bclk) begin
        n_fails++;
        $display("FAIL R7 (%s): bit_clk=%0b expected=%0b", tag, bit_clk, m_bclk);
      end
      n_checks++;
      if (dac_code == -10'sd512) begin
        n_fails++;
        $display("FAIL R10: dac_code=%0d expected>-512", dac_code);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, bit ok, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int lfsr = 32'h1ACE;
    // R9 reset state
    tag = "R9";
    run(5);
    check("R9", dac_code == 0 && bit_clk == 0, int'(dac_code), 0);
    rst_n = 1'b1;
    run(2);
    check("R9", dac_code == 0 && bit_clk == 0, int'(dac_code), 0);
    run(4);

    // R1 carriers
    tag = "R1";
    baud_sel = 2'd2; dev_full = 1'b1; tx_en = 1'b1;
    for (int ch = 0; ch < 8; ch++) begin
      chan_sel = 3'(ch); tx_data = 1'b0; run(1500);
      tx_data = 1'b1; run(1500);
    end

    // R2 rates and spacing
    tag = "R2";
    chan_sel = 3'd5;
    for (int bd = 0; bd < 4; bd++) begin
      for (int dv = 0; dv < 2; dv++) begin
        if (!(bd == 3 && dv == 0)) begin
          baud_sel = 2'(bd); dev_full = dv[0];
          tx_data = 1'b0; run(700); tx_data = 1'b1; run(700);
        end
      end
    end

    // R3 forbidden pair
    tag = "R3";
    chan_sel = 3'd2; baud_sel = 2'd3; dev_full = 1'b0;
    for (int i = 0; i < 8; i++) begin tx_data = ~tx_data; run(400); end

    // R5 fast toggling, change deferred to zero crossing
    tag = "R5";
    chan_sel = 3'd7; dev_full = 1'b1; baud_sel = 2'd1;
    for (int i = 0; i < 430; i++) begin tx_data = ~tx_data; run(7); end
    chan_sel = 3'd0; run(300);

    // R4 disable mid tone
    tag = "R4";
    run(37);
    tx_en = 1'b0; run(2);
    check("R4", dac_code == 0, int'(dac_code), 0);
    check("R4", bit_clk == 0, int'(bit_clk), 0);
    run(40);
    tx_en = 1'b1; run(1500);

    // R7 synchronous capture
    tag = "R7";
    sync_mode = 1'b1; tx_en = 1'b0; baud_sel = 2'd3; chan_sel = 3'd4; run(3);
    tx_en = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tx_data = lfsr[3]; run(13);
    end
    baud_sel = 2'd2;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tx_data = lfsr[5]; run(11);
    end

    // R8 asynchronous direct data
    tag = "R8";
    sync_mode = 1'b0; chan_sel = 3'd6;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tx_data = lfsr[7]; run(150);
    end

    // R10 explicit
    check("R10", dac_code != -10'sd512, int'(dac_code), 0);
    finish_up();
  end
endmodule